// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a synchronous SRAM in which reads and writes can be issued on every clock with no idle cycle between them. Address, access type and byte-lane strobes are captured on a rising edge. A read returns its word through an output register one enabled edge later. A write takes its data from the input bus one enabled edge after that, which is the same slot in which read data would appear. Mixing the two therefore never costs a turnaround cycle. Deselects travel down the same pipeline.

The control path holds two stages, each in one of three states: `OP_IDLE`, `OP_READ` or `OP_WRITE`. At every enabled edge the capture stage moves to a new state:
- **start-read**: all selects are active, the load strobe is low and the write strobe is high.
- **start-write**: the same conditions, with the write strobe low.
- **bubble**: any other case, which leaves the stage in `OP_IDLE`.

The second stage always takes over the state that the capture stage held before the edge (**advance**). When the active-low clock enable is high, neither stage moves (**hold**).

The data bus is modelled as a separate input and output, plus a drive-enable output that stands for the tri-state driver. A sleep input blocks new accesses and silences the driver. Operations already accepted are allowed to finish. Burst address generation is left to a neighbouring block.

Top module: `zt_sram`

## Requirements
- R1: While `clk_en_n` is high at a rising edge, that edge has no effect: the pipeline stages, `dq_out`, `dq_oe` and the array all keep their values.
- R2: An access is captured only at an edge where all of the following hold: `clk_en_n`=0, `sel0_n`=0, `sel1`=1, `sel2_n`=0, `load_n`=0 and `sleep`=0. At capture, `wr_n`=1 selects a read and `wr_n`=0 selects a write.
- R3: For a read captured at enabled edge k, the addressed word appears on `dq_out` with `dq_oe`=1 after enabled edge k+1, provided `drive_en_n`=0. It stays there until the next enabled edge.
- R4: `dq_oe` is 0 whenever `drive_en_n` is 1, and it follows `drive_en_n` without waiting for a clock.
- R5: A capture edge that fails R2 (any select inactive, or `load_n`=1) starts nothing. `dq_oe` is then 0 after the following enabled edge, and the array is unchanged.
- R6: For a write captured at enabled edge k, `dq_oe` is 0 after edge k+1 whatever `drive_en_n` is doing. `dq_in` is sampled at enabled edge k+2.
- R7: `lane_wr_n[i]`=0, captured with the write address, updates bits [9i+8:9i] of the word, where bit 9i+8 is that lane's parity bit. Lanes with a strobe of 1 keep their old contents.
- R8: Reads and writes may alternate on every edge. A read captured one edge after a write to the same address returns the newly written lanes merged with the lanes that were not written.
- R9: While `sleep`=1, no access is captured and `dq_oe` is 0. A write accepted before `sleep` rose still commits its data.
- R10: After `rst_n` is low, both pipeline stages are idle and `dq_oe` is 0. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| load_n | input | 1 | Active-low strobe to start a new access |
| wr_n | input | 1 | Access type at capture: 1 read, 0 write |
| lane_wr_n | input | LANES | Active-low per-lane write strobes |
| addr | input | AW | Word address |
| dq_in | input | LANES*LW | Write data bus |
| drive_en_n | input | 1 | Asynchronous active-low output drive enable |
| sleep | input | 1 | Active-high low-activity request |
| dq_out | output | LANES*LW | Registered read data |
| dq_oe | output | 1 | Data driver enable (1 = bus driven) |

## Verification
Each result has a fixed due point counted in enabled edges from the capture edge. Read data and the driver enable are due one enabled edge after capture. Write data is consumed at the second enabled edge, and a read of that word is due one enabled edge after the read's own capture. The bench keeps a two-slot model that advances only on edges where `clk_en_n` is low. It compares `dq_oe` and `dq_out` at the falling edge after every rising edge, so held edges shift every due point by exactly the number of held cycles. The model fills a word from `dq_in` only at the edge where a write leaves the second slot, and this gives the merged value expected for a read that directly follows a write.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // State of one pipeline stage.
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
    import zt_sram_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en_n,
    input  logic             sel0_n,
    input  logic             sel1,
    input  logic             sel2_n,
    input  logic             load_n,
    input  logic             wr_n,
    input  logic             sleep,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] lane_wr_n,
    output op_e              s1_op,
    output logic [AW-1:0]    s1_addr,
    output logic [LANES-1:0] s1_lane_n,
    output op_e              s2_op,
    output logic [AW-1:0]    s2_addr,
    output logic [LANES-1:0] s2_lane_n
);

    logic selected;
    op_e  nxt_op;

    // Next state of the capture stage: start-read, start-write or bubble.
    always_comb begin
        selected = !sel0_n && sel1 && !sel2_n;
        nxt_op   = OP_IDLE;
        if (selected && !load_n && !sleep) begin
            nxt_op = wr_n ? OP_READ : OP_WRITE;
        end
    end

    // State register: capture stage and second stage advance together.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_op     <= OP_IDLE;
            s2_op     <= OP_IDLE;
            s1_addr   <= '0;
            s2_addr   <= '0;
            s1_lane_n <= '1;
            s2_lane_n <= '1;
        end else if (!clk_en_n) begin
            s2_op     <= s1_op;
            s2_addr   <= s1_addr;
            s2_lane_n <= s1_lane_n;
            s1_op     <= nxt_op;
            if (nxt_op != OP_IDLE) begin
                s1_addr   <= addr;
                s1_lane_n <= lane_wr_n;
            end
        end
    end

    // R1: a held edge leaves every stage untouched
    p_hold_stages_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(s1_op) && $stable(s2_op) && $stable(s1_addr) && $stable(s2_addr)));

    // R5: an inactive select or a high load strobe leaves the capture stage idle
    p_desel_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && (load_n || sel0_n || !sel1 || sel2_n)) |=> (s1_op == OP_IDLE));

    // R9: sleep blocks any capture
    p_sleep_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && sleep) |=> (s1_op == OP_IDLE));

    // R2: the access type follows the write strobe at a valid capture
    p_type_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n && !sel0_n && sel1 && !sel2_n && !sleep && !wr_n)
            |=> (s1_op == OP_WRITE));

endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
    parameter int AW    = 4,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                clk_en_n,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [LANES-1:0]    wlane_n,
    input  logic [LANES*LW-1:0] wdata,
    input  logic [AW-1:0]       raddr,
    output logic [LANES*LW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;
    localparam int DW    = LANES * LW;

    logic [DW-1:0] mem [DEPTH];

    // One write port per lane, so each byte lane with its parity bit is updated on its own.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!clk_en_n && we && !wlane_n[l]) begin
                mem[waddr][l*LW +: LW] <= wdata[l*LW +: LW];
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/zt_sram_outq.sv
module zt_sram_outq
    import zt_sram_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en_n,
    input  op_e                 s1_op,
    input  logic [AW-1:0]       s1_addr,
    input  op_e                 s2_op,
    input  logic [AW-1:0]       s2_addr,
    input  logic [LANES-1:0]    s2_lane_n,
    input  logic [LANES*LW-1:0] wdata,
    input  logic [LANES*LW-1:0] rdata,
    input  logic                drive_en_n,
    input  logic                sleep,
    output logic [LANES*LW-1:0] dq_out,
    output logic                dq_oe
);

    localparam int DW = LANES * LW;

    logic [DW-1:0] merged;
    logic          rd_vld;

    // Forward lanes committed at this same edge to a read of the same word.
    for (genvar l = 0; l < LANES; l++) begin : g_byp
        logic hit;
        assign hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr) && !s2_lane_n[l];
        assign merged[l*LW +: LW] = hit ? wdata[l*LW +: LW] : rdata[l*LW +: LW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
            dq_out <= '0;
        end else if (!clk_en_n) begin
            unique case (s1_op)
                OP_READ: begin
                    rd_vld <= 1'b1;
                    dq_out <= merged;
                end
                OP_WRITE, OP_IDLE: rd_vld <= 1'b0;
                default:           rd_vld <= 1'b0;
            endcase
        end
    end

    assign dq_oe = rd_vld && !drive_en_n && !sleep;

    // R4: the asynchronous drive enable gates the driver
    p_oe_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_n |-> !dq_oe);

    // R9: no driving while asleep
    p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_oe);

    // R6: the write slot never drives the bus
    p_wr_turn_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && s1_op == OP_WRITE) |=> !dq_oe);

    // R3: a read slot drives unless the enable or sleep forbids it
    p_rd_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && s1_op == OP_READ) |=> (dq_oe || drive_en_n || sleep));

    // R1: held edges keep the output register
    p_hold_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> $stable(dq_out));

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int AW    = 4,
    parameter int LANES = 4,
    parameter int LW    = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en_n,
    input  logic                sel0_n,
    input  logic                sel1,
    input  logic                sel2_n,
    input  logic                load_n,
    input  logic                wr_n,
    input  logic [LANES-1:0]    lane_wr_n,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] dq_in,
    input  logic                drive_en_n,
    input  logic                sleep,
    output logic [LANES*LW-1:0] dq_out,
    output logic                dq_oe
);

    localparam int DW = LANES * LW;

    op_e              s1_op, s2_op;
    logic [AW-1:0]    s1_addr, s2_addr;
    logic [LANES-1:0] s1_lane_n, s2_lane_n;
    logic [DW-1:0]    rdata;

    zt_sram_ctrl #(.AW(AW), .LANES(LANES)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .sel0_n    (sel0_n),
        .sel1      (sel1),
        .sel2_n    (sel2_n),
        .load_n    (load_n),
        .wr_n      (wr_n),
        .sleep     (sleep),
        .addr      (addr),
        .lane_wr_n (lane_wr_n),
        .s1_op     (s1_op),
        .s1_addr   (s1_addr),
        .s1_lane_n (s1_lane_n),
        .s2_op     (s2_op),
        .s2_addr   (s2_addr),
        .s2_lane_n (s2_lane_n)
    );

    zt_sram_array #(.AW(AW), .LANES(LANES), .LW(LW)) i_array (
        .clk      (clk),
        .clk_en_n (clk_en_n),
        .we       (s2_op == OP_WRITE),
        .waddr    (s2_addr),
        .wlane_n  (s2_lane_n),
        .wdata    (dq_in),
        .raddr    (s1_addr),
        .rdata    (rdata)
    );

    zt_sram_outq #(.AW(AW), .LANES(LANES), .LW(LW)) i_outq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en_n   (clk_en_n),
        .s1_op      (s1_op),
        .s1_addr    (s1_addr),
        .s2_op      (s2_op),
        .s2_addr    (s2_addr),
        .s2_lane_n  (s2_lane_n),
        .wdata      (dq_in),
        .rdata      (rdata),
        .drive_en_n (drive_en_n),
        .sleep      (sleep),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

endmodule

// File: tb/test_zt_sram.sv
module test_zt_sram;

    localparam int CLK_P = 10;
    localparam int AW    = 4;
    localparam int LANES = 4;
    localparam int LW    = 9;
    localparam int DW    = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en_n = 1'b0;
    logic             sel0_n = 1'b0, sel1 = 1'b1, sel2_n = 1'b0;
    logic             load_n = 1'b1, wr_n = 1'b1;
    logic [LANES-1:0] lane_wr_n = '1;
    logic [AW-1:0]    addr = '0;
    logic [DW-1:0]    dq_in = '0;
    logic             drive_en_n = 1'b0, sleep = 1'b0;
    logic [DW-1:0]    dq_out;
    logic             dq_oe;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model: slot 1 = captured at the last enabled edge, slot 2 = the one before.
    int               m1_k = 0, m2_k = 0;      // 0 idle, 1 read, 2 write
    logic [AW-1:0]    m1_a, m2_a;
    logic [LANES-1:0] m1_l, m2_l;
    logic [DW-1:0]    m1_d, m2_d;
    logic [DW-1:0]    cur_d = '0;
    logic [DW-1:0]    ref_mem [DEPTH];
    logic             exp_vld = 1'b0;
    logic [DW-1:0]    exp_dout = '0;

    always #(CLK_P/2) clk = ~clk;

    zt_sram #(.AW(AW), .LANES(LANES), .LW(LW)) i_zt_sram (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .load_n(load_n), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
        .dq_in(dq_in), .drive_en_n(drive_en_n), .sleep(sleep),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [DW-1:0] pat(input int s);
        return {9'(s * 29 + 3), 9'(s * 17 + 101), 9'(s * 5 + 200), 9'(s * 61 + 11)};
    endfunction

    task automatic chk(input string tag, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One clock: update the model at the rising edge, check outputs mid-cycle.
    task automatic tick(input string tag);
        logic cap;
        @(posedge clk);
        if (!clk_en_n) begin
            if (m2_k == 2) begin
                for (int l = 0; l < LANES; l++)
                    if (!m2_l[l]) ref_mem[m2_a][l*LW +: LW] = dq_in[l*LW +: LW];
            end
            if (m1_k == 1) begin
                exp_vld  = 1'b1;
                exp_dout = ref_mem[m1_a];
            end else begin
                exp_vld = 1'b0;
            end
            m2_k = m1_k; m2_a = m1_a; m2_l = m1_l; m2_d = m1_d;
            cap = !sel0_n && sel1 && !sel2_n && !load_n && !sleep;
            m1_k = cap ? (wr_n ? 1 : 2) : 0;
            m1_a = addr; m1_l = lane_wr_n; m1_d = cur_d;
        end
        @(negedge clk);
        chk(tag, "dq_oe", DW'(dq_oe), DW'(exp_vld && !drive_en_n && !sleep));
        if (exp_vld && !drive_en_n && !sleep)
            chk(tag, "dq_out", dq_out, exp_dout);
        dq_in = (m2_k == 2) ? m2_d : '0;
    endtask

    task automatic op_rd(input int a);
        load_n = 1'b0; wr_n = 1'b1; addr = AW'(a); lane_wr_n = '1;
    endtask

    task automatic op_wr(input int a, input logic [LANES-1:0] ln, input logic [DW-1:0] d);
        load_n = 1'b0; wr_n = 1'b0; addr = AW'(a); lane_wr_n = ln; cur_d = d;
    endtask

    task automatic op_nop();
        load_n = 1'b1; wr_n = 1'b1;
    endtask

    initial begin : watchdog
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R10: reset state, driver off
        chk("R10", "dq_oe after reset", DW'(dq_oe), '0);
        rst_n = 1'b1;
        op_nop();
        tick("R10");

        // R2 R8: fill every word back to back with full-lane writes
        for (int a = 0; a < DEPTH; a++) begin
            op_wr(a, '0, pat(a));
            tick("R2");
        end
        // R3: read every word back to back
        for (int a = 0; a < DEPTH; a++) begin
            op_rd(a);
            tick("R3");
        end
        op_nop(); tick("R3"); tick("R3");

        // R7 R8: partial write immediately followed by a read of the same word
        for (int a = 0; a < DEPTH; a++) begin
            op_wr(a, LANES'(a), pat(a + 100));
            tick("R7");
            op_rd(a);
            tick("R8");
        end
        // R8: alternate write/read to different words every cycle
        for (int a = 0; a < DEPTH; a++) begin
            op_wr(a, LANES'(~a), pat(a + 300));
            tick("R8");
            op_rd((a + 5) % DEPTH);
            tick("R8");
        end
        // R7: read all words to confirm unselected lanes kept their contents
        for (int a = 0; a < DEPTH; a++) begin
            op_rd(a);
            tick("R7");
        end

        // R4: reads while the drive enable is high
        op_rd(2); tick("R4");
        drive_en_n = 1'b1;
        op_rd(3); tick("R4");
        op_nop(); tick("R4");
        drive_en_n = 1'b0;
        tick("R4");

        // R6: write slots keep the driver off even with the enable low
        op_rd(4); tick("R6");
        op_wr(4, '0, pat(500)); tick("R6");
        op_rd(4); tick("R6");
        op_nop(); tick("R6"); tick("R6");

        // R5: each select inactive in turn, with a write that must not land
        op_rd(1); tick("R5");
        op_wr(1, '0, pat(700)); sel0_n = 1'b1; tick("R5");
        sel0_n = 1'b0; sel1 = 1'b0; tick("R5");
        sel1 = 1'b1; sel2_n = 1'b1; tick("R5");
        sel2_n = 1'b0; load_n = 1'b1; wr_n = 1'b0; tick("R5");
        op_rd(1); tick("R5");
        op_nop(); tick("R5"); tick("R5");

        // R1: held edges in the middle of a write and a read
        op_wr(6, 4'b0101, pat(800)); tick("R1");
        clk_en_n = 1'b1; op_rd(9); tick("R1");
        addr = 4'd12; wr_n = 1'b0; tick("R1");
        clk_en_n = 1'b0; op_rd(6); tick("R1");
        clk_en_n = 1'b1; op_wr(7, '0, pat(900)); tick("R1"); tick("R1");
        clk_en_n = 1'b0; op_nop(); tick("R1"); tick("R1");
        op_rd(6); tick("R1");
        op_rd(7); tick("R1");
        op_nop(); tick("R1"); tick("R1");

        // R9: write accepted, then sleep blocks new accesses and the driver
        op_rd(0); tick("R9");
        op_wr(5, '0, pat(1000)); tick("R9");
        sleep = 1'b1; op_rd(5); tick("R9");
        op_wr(6, '0, pat(1100)); tick("R9");
        op_rd(6); tick("R9"); tick("R9");
        sleep = 1'b0; op_rd(5); tick("R9");
        op_rd(6); tick("R9");
        op_nop(); tick("R9"); tick("R9");

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule